// File: doc/BRIEF.md
# Redundant-Binary Booth Multiplier

This block multiplies two signed N-bit two's-complement operands and returns the full 2N-bit signed product. The multiplier operand is recoded into radix-4 Booth digits in {-2,-1,0,+1,+2}. Each digit selects a signed multiple of the multiplicand. Pairs of adjacent Booth rows are merged into a single redundant-binary row: the even row goes into the positive vector and the negated odd row into the negative vector. This leaves N/4 redundant-binary rows.

The rows are summed pairwise by carry-free redundant-binary adders. Each adder level halves the row count, so log2(N/4) levels reduce the rows to one. The digit rule in each adder position looks only at the operand digits one position lower, so no carry travels more than one position. A final converter subtracts the negative vector from the positive one. It uses a parallel-prefix carry network on the lower half and carry-select on the upper half, and produces the two's-complement product.

Optional registers sit after the row generator and after every adder level. Each one is enabled by a bit of a parameter mask, and all of them advance together under a valid/ready handshake. N must be a multiple of 8 with N/4 a power of two (8, 16, 32, 64).

Top module: `rb_booth_mul`

## Requirements
- R1: `product` equals the signed product of `a` and `b`, both read as two's complement, as a 2N-bit two's-complement value, for every operand pair and for N = 8 and N = 16.
- R2: The most negative operand times itself (-2^(N-1) squared) gives the positive value 2^(2N-2), with no overflow into the sign bit.
- R3: A zero on either operand gives an all-zero product.
- R4: An operand of -1 (all ones) gives the two's-complement negation of the other operand.
- R5: With `out_ready` held high, a result appears on `out_valid` exactly LAT cycles after the cycle its operands are accepted. LAT is the number of set bits among the low log2(N/4)+1 bits of `REG_MASK`. Bit 0 is the register after the row generator and bit k is the register after adder level k. Under backpressure a result is never earlier than LAT cycles.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `product` hold their values into the next cycle and `in_ready` is low.
- R7: Every accepted operand pair yields exactly one result, in acceptance order, and the pipeline never holds more than LAT pending results.
- R8: During and right after reset `out_valid` is low and, with nothing pending, `in_ready` is high.
- R9: While `out_ready` is high, `in_ready` is high, so one operand pair can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Operand pair is taken on this edge when valid |
| a | input | N | Multiplicand, two's complement |
| b | input | N | Multiplier, two's complement, Booth-recoded |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| product | output | 2N | Signed product, two's complement |

## Verification
The bench samples every output half a cycle after the rising edge. It records the cycle in which each operand pair is taken, so a result from the default 16-bit configuration with all three registers enabled must appear exactly three cycles later when the consumer never stalls, and no earlier than that when it does. Each expected product waits in a queue until the monitor sees the handshake complete on the output side. The 8-bit configuration has no registers, so its product must be correct in the same cycle as the operands. It is checked half a cycle after they change, for every operand pair.

// File: rtl/rb_booth_mul.sv
module rb_booth_mul #(
  parameter int N = 16,
  parameter logic [7:0] REG_MASK = 8'hFF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*N-1:0] product
);
  localparam int W = 2 * N;
  localparam int R = N / 4;
  localparam int L = $clog2(R);
  localparam int D = N / 2;
  localparam int H = N;
  localparam int LOGH = $clog2(H);

  function automatic int count_regs(input logic [7:0] m, input int levels);
    int c = 0;
    for (int k = 0; k <= levels; k++) c += int'(m[k]);
    return c;
  endfunction
  localparam int LAT = count_regs(REG_MASK, L);

  function automatic logic [2*W-1:0] rb_sum(input logic [W-1:0] xp, xm, yp, ym);
    logic [W-1:0] zp, zm;
    int s, w, cin, cout;
    logic nn;
    zp = '0; zm = '0; cin = 0; nn = 1'b1;
    for (int i = 0; i < W; i++) begin
      s = (xp[i] ? 1 : 0) - (xm[i] ? 1 : 0) + (yp[i] ? 1 : 0) - (ym[i] ? 1 : 0);
      case (s)
        2:  begin cout = 1;  w = 0; end
        -2: begin cout = -1; w = 0; end
        1:  if (nn) begin cout = 1; w = -1; end else begin cout = 0;  w = 1; end
        -1: if (nn) begin cout = 0; w = -1; end else begin cout = -1; w = 1; end
        default: begin cout = 0; w = 0; end
      endcase
      zp[i] = (w + cin) == 1;
      zm[i] = (w + cin) == -1;
      cin = cout;
      nn = !(xm[i] && !xp[i]) && !(ym[i] && !yp[i]);
    end
    return {zp, zm};
  endfunction

  logic [W-1:0] gp [R];
  logic [W-1:0] gm [R];
  logic [N:0]   bx;
  logic [W-1:0] ax, mag, val;
  logic [2:0]   trip;
  logic         one, two, neg;

  assign bx = {b, 1'b0};
  assign ax = {{N{a[N-1]}}, a};

  always_comb begin
    for (int j = 0; j < R; j++) begin
      gp[j] = '0;
      gm[j] = '0;
    end
    trip = '0; one = 1'b0; two = 1'b0; neg = 1'b0; mag = '0; val = '0;
    for (int i = 0; i < D; i++) begin
      trip = bx[2*i +: 3];
      one  = trip[1] ^ trip[0];
      two  = (trip == 3'b100) || (trip == 3'b011);
      neg  = trip[2] && !(trip[1] && trip[0]);
      mag  = two ? {ax[W-2:0], 1'b0} : (one ? ax : '0);
      val  = (neg ? -mag : mag) << (2 * i);
      if (i % 2 == 0) gp[i/2] = val;
      else            gm[i/2] = -val;
    end
  end

  logic adv;

  for (genvar k = 0; k <= L; k++) begin : g_lvl
    localparam int RK = R >> k;
    logic [W-1:0] cp [RK];
    logic [W-1:0] cm [RK];
    logic [W-1:0] rp [RK];
    logic [W-1:0] rm [RK];
    logic vi, rv;
    if (k == 0) begin : g_src
      assign cp = gp;
      assign cm = gm;
      assign vi = in_valid;
    end else begin : g_add
      assign vi = g_lvl[k-1].rv;
      for (genvar j = 0; j < RK; j++) begin : g_pair
        assign {cp[j], cm[j]} = rb_sum(g_lvl[k-1].rp[2*j], g_lvl[k-1].rm[2*j],
                                       g_lvl[k-1].rp[2*j+1], g_lvl[k-1].rm[2*j+1]);
      end
    end
    if (REG_MASK[k]) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)   rv <= 1'b0;
        else if (adv) rv <= vi;
      always_ff @(posedge clk)
        if (adv) begin
          rp <= cp;
          rm <= cm;
        end
    end else begin : g_wire
      assign rv = vi;
      assign rp = cp;
      assign rm = cm;
    end
  end

  logic [W-1:0] fp, fm;
  assign fp = g_lvl[L].rp[0];
  assign fm = g_lvl[L].rm[0];
  assign out_valid = g_lvl[L].rv;
  assign adv = out_ready || !out_valid;
  assign in_ready = adv;

  logic [LOGH:0][H-1:0]   kg;
  logic [LOGH-1:0][H-1:0] kp;
  logic [H-1:0] lo, xl, yl;
  logic [N-1:0] hi0, hi1;

  always_comb begin
    xl = fp[H-1:0];
    yl = ~fm[H-1:0];
    kg = '0;
    kp = '0;
    kg[0] = xl & yl;
    kp[0] = xl ^ yl;
    kg[0][0] = kg[0][0] | kp[0][0];
    for (int s = 1; s <= LOGH; s++) begin
      for (int i = 0; i < H; i++) begin
        if (i >= (1 << (s - 1))) begin
          kg[s][i] = kg[s-1][i] | (kp[s-1][i] & kg[s-1][i - (1 << (s - 1))]);
          if (s < LOGH) kp[s][i] = kp[s-1][i] & kp[s-1][i - (1 << (s - 1))];
        end else begin
          kg[s][i] = kg[s-1][i];
          if (s < LOGH) kp[s][i] = kp[s-1][i];
        end
      end
    end
    lo[0] = ~kp[0][0];
    for (int i = 1; i < H; i++) lo[i] = kp[0][i] ^ kg[LOGH][i-1];
  end

  assign hi0 = fp[W-1:H] + ~fm[W-1:H];
  assign hi1 = hi0 + 1'b1;
  assign product = {kg[LOGH][H-1] ? hi1 : hi0, lo};
endmodule

// File: rtl/rb_booth_mul_chk.sv
module rb_booth_mul_chk #(
  parameter int W = 32,
  parameter int LAT = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] product
);
  logic [7:0] occ;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) occ <= '0;
    else occ <= occ + 8'(in_valid && in_ready) - 8'(out_valid && out_ready);

  // R6
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(product)));

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= LAT);

  // R8
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LAT > 0 && occ == 8'd0) |-> !out_valid);

  // R9
  ready_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  // R8
  known_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({out_valid, in_ready}));
endmodule

bind rb_booth_mul rb_booth_mul_chk #(.W(2*N), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .product(product)
);

// File: tb/rb_booth_mul_bench.sv
module rb_booth_mul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int W = 2 * N;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [N-1:0] a = '0, b = '0;
  logic [W-1:0] product;

  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  logic        rdy8, vld8;

  rb_booth_mul #(.N(N), .REG_MASK(8'hFF)) u_rb_booth_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a(a), .b(b), .out_valid(out_valid), .out_ready(out_ready), .product(product));

  rb_booth_mul #(.N(8), .REG_MASK(8'h00)) u_rb_booth_mul_n8 (
    .clk(clk), .rst_n(rst_n), .in_valid(1'b1), .in_ready(rdy8),
    .a(a8), .b(b8), .out_valid(vld8), .out_ready(1'b1), .product(p8));

  int checks = 0, fails = 0, cyc = 0;
  bit free_run = 1'b1, stall_mode = 1'b0, done = 1'b0;
  logic [W-1:0] exp_q[$];
  int cyc_q[$];
  string tag_q[$];
  logic prev_stall = 1'b0;
  logic [W-1:0] prev_prod = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
    longint p;
    p = longint'($signed(x)) * longint'($signed(y));
    return p[W-1:0];
  endfunction

  task automatic send(input logic [N-1:0] x, input logic [N-1:0] y, input string tag);
    @(negedge clk);
    a = x; b = y; in_valid = 1'b1;
    #1;
    if (free_run) check(in_ready === 1'b1, "R9 in_ready with out_ready high", 64'(in_ready), 64'd1);
    while (in_ready !== 1'b1) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(ref_mul(x, y));
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    do idle(1); while (exp_q.size() != 0);
    idle(4);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(negedge clk)
    out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (prev_stall)
        check(out_valid === 1'b1 && product === prev_prod, "R6 result held while stalled", 64'(product), 64'(prev_prod));
      if (out_valid && !out_ready)
        check(in_ready === 1'b0, "R6 in_ready low while stalled", 64'(in_ready), 64'd0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 result without accepted operands", 64'(product), 64'd0);
        end else begin
          logic [W-1:0] e;
          int c;
          string t;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          t = tag_q.pop_front();
          check(product === e, t, 64'(product), 64'(e));
          if (free_run) check(cyc - c == LAT, "R5 exact latency", 64'(cyc - c), 64'(LAT));
          else          check(cyc - c >= LAT, "R5 minimum latency", 64'(cyc - c), 64'(LAT));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_prod = product;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "R7 watchdog expired", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(out_valid === 1'b0, "R8 out_valid low in reset", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R8 idle after reset", 64'({out_valid, in_ready}), 64'b01);

    send(16'h8000, 16'h8000, "R2 min times min");
    send(16'h0000, 16'h7123, "R3 zero multiplicand");
    send(16'h9ABC, 16'h0000, "R3 zero multiplier");
    send(16'hFFFF, 16'h1234, "R4 minus one multiplicand");
    send(16'h8000, 16'hFFFF, "R4 minus one multiplier");
    send(16'hFFFF, 16'hFFFF, "R4 minus one squared");
    send(16'h7FFF, 16'h7FFF, "R1 max times max");
    send(16'h8000, 16'h7FFF, "R1 min times max");
    send(16'h5555, 16'hAAAA, "R1 alternating bits");
    send(16'h0001, 16'h0001, "R1 one times one");
    repeat (60) send(N'($urandom), N'($urandom), "R1 random operands");
    drain();

    free_run = 1'b0;
    stall_mode = 1'b1;
    repeat (150) begin
      send(N'($urandom), N'($urandom), "R1 random under backpressure");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    send(16'h8000, 16'h8000, "R2 min times min under backpressure");
    drain();
    stall_mode = 1'b0;
    idle(2);
    free_run = 1'b1;
    check(exp_q.size() == 0, "R7 every result delivered", 64'(exp_q.size()), 64'd0);

    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        logic [15:0] e8;
        @(negedge clk);
        a8 = i[7:0];
        b8 = j[7:0];
        #1;
        e8 = 16'(int'($signed(a8)) * int'($signed(b8)));
        check(p8 === e8, (i == 128 && j == 128) ? "R2 N=8 min times min" : "R1 N=8 exhaustive", 64'(p8), 64'(e8));
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule